// File: doc/BRIEF.md
# Serial Peripheral Low-Power Stop Controller

This block is the shared control slice of a peripheral that contains two serial engines: a queued SPI and an asynchronous serial port. It holds a configuration word with a stop bit, a halt request and a halt acknowledge. It also holds an interrupt word that packs an 8-bit priority-level byte and an 8-bit vector byte, and a small command-queue RAM that the SPI engine reads. A CPU reaches all of this over a 16-bit register bus with byte enables. The block gives the serial engines a synchronous clock enable in place of a gated clock.

Setting the stop bit drops the clock enable one cycle later and places the peripheral in low-power stop. Reset also sets the stop bit. While stopped, only the configuration word reads back real data. Every other address, the queue RAM included, reads as zero and raises no bus error. Writes to every register and to the RAM still take effect. Before software sets stop, it sets the halt request. The SPI engine keeps the request pending until its current queue entry has finished, or until it is idle. The acknowledge is then raised, and software can set stop safely.

The bus has no back-pressure. A request is accepted in the cycle `bus_sel` is high. A read returns `bus_rdata` with `bus_rvalid` high exactly one cycle later. Reads and writes are never issued in the same cycle. Word addresses: 0 is the configuration word, 1 is the interrupt word, and any address with its top bit set selects a queue RAM entry through its low bits. Every other address is unmapped.

Top module: `sermod_stop_ctrl`

## Requirements
- R1: After reset, the stop bit is 1, halt request and acknowledge are 0, `sub_clk_en` is 0, the level is 0, the vector is 0x0F, the arbitration field is 0 and `bus_rvalid` is 0.
- R2: `sub_clk_en` goes low on the cycle after the configuration word is written with byte enable 1 set and bit 15 = 1. It goes high on the cycle after the same write with bit 15 = 0. A write with byte enable 1 clear leaves the stop bit unchanged.
- R3: The configuration word reads as {bit15 stop, bit7 halt request, bit6 halt acknowledge, bits3:0 arbitration field}, in stop mode and out of it.
- R4: While stop is 1, a read of any address other than 0 returns 0x0000 with `bus_rvalid` high.
- R5: Writes to the interrupt word and to the queue RAM while stopped take effect, and can be read back after stop clears.
- R6: The interrupt word holds the level in bits 10:8 and the vector in bits 7:0. Byte enable 1 writes the level and byte enable 0 writes the vector, each independently. Both also drive `irq_level` and `irq_vector`.
- R7: Unimplemented bits (configuration bits 14:8 and 5:4, interrupt bits 15:11) ignore writes and read as 0. Unmapped addresses always read 0.
- R8: The halt acknowledge rises only on the cycle after a cycle in which the halt request was set and either `spi_entry_end` was high or `spi_active` was low. It never rises during a transfer.
- R9: The halt acknowledge clears on the cycle after a cycle in which the halt request is 0.
- R10: The halt acknowledge bit cannot be written.
- R11: Every read gets `bus_rvalid` and `bus_rdata` exactly one cycle after the request.
- R12: `spi_ram_data` shows, combinationally, the queue RAM entry selected by `spi_ram_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 2 | Byte enables, bit 1 = high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| sub_clk_en | output | 1 | Clock enable to the serial engines |
| spi_halt_req | output | 1 | Halt request to the SPI engine |
| spi_active | input | 1 | SPI engine is inside a transfer |
| spi_entry_end | input | 1 | Pulse at the end of a queue entry's transfer |
| spi_ram_idx | input | RAM_AW | SPI read index into the queue RAM |
| spi_ram_data | output | 16 | Queue RAM entry at `spi_ram_idx` |
| irq_level | output | 3 | Interrupt priority level |
| irq_vector | output | 8 | Interrupt vector |

## Verification
A stop bit stuck at the wrong value shows on `sub_clk_en` on the very next cycle. It also shows in the read data of the next access to any address other than 0. A read mask that stays open in stop mode leaks nonzero data one cycle after the read. A write path blocked in stop mode stays hidden until stop clears and the entry is read back. An acknowledge that leads, lags or sticks shows in the next configuration read.

// File: rtl/sermod_pkg.sv
package sermod_pkg;
  localparam int DATA_W    = 16;
  localparam int LVL_W     = 3;
  localparam int VEC_W     = 8;
  localparam int ARB_W     = 4;
  localparam int STOP_BIT  = 15;
  localparam int HALT_BIT  = 7;
  localparam int HACK_BIT  = 6;
  localparam logic [VEC_W-1:0] VEC_RESET = 8'h0F;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_INT  = 2'd2,
    SEL_RAM  = 2'd3
  } region_e;
endpackage

// File: rtl/sermod_regs.sv
module sermod_regs
  import sermod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              int_we,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              halt_ack_i,
  output logic              stop_o,
  output logic              halt_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DATA_W-1:0] cfg_word_o,
  output logic [DATA_W-1:0] int_word_o
);
  logic             stop_q, halt_q;
  logic [ARB_W-1:0] arb_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[14:11];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      halt_q <= 1'b0;
      arb_q  <= '0;
      lvl_q  <= '0;
      vec_q  <= VEC_RESET;
    end else begin
      if (cfg_we && be[1]) stop_q <= wdata[STOP_BIT];
      if (cfg_we && be[0]) begin
        halt_q <= wdata[HALT_BIT];
        arb_q  <= wdata[ARB_W-1:0];
      end
      if (int_we && be[1]) lvl_q <= wdata[8 +: LVL_W];
      if (int_we && be[0]) vec_q <= wdata[VEC_W-1:0];
    end
  end

  assign stop_o     = stop_q;
  assign halt_o     = halt_q;
  assign lvl_o      = lvl_q;
  assign vec_o      = vec_q;
  assign cfg_word_o = {stop_q, 7'b0, halt_q, halt_ack_i, 2'b0, arb_q};
  assign int_word_o = {{(8-LVL_W){1'b0}}, lvl_q, vec_q};

  // R2: a byte-1 write of the stop bit lands on the next cycle
  assert_stop_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && be[1]) |=> (stop_q == $past(wdata[STOP_BIT])));
endmodule

// File: rtl/sermod_halt.sv
module sermod_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic spi_active,
  input  logic spi_entry_end,
  output logic halt_ack_o
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= halt_i && (ack_q || spi_entry_end || !spi_active);
  end

  assign halt_ack_o = ack_q;

  // R8: acknowledge rises only at an entry boundary or when idle
  assert_ack_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> ($past(halt_i) && ($past(spi_entry_end) || !$past(spi_active))));
  // R9: acknowledge drops once the request is gone
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_i |=> !ack_q);
endmodule

// File: rtl/sermod_qram.sv
module sermod_qram
  import sermod_pkg::*;
#(
  parameter int RAM_AW = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [1:0]        be,
  input  logic [RAM_AW-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RAM_AW-1:0] ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [RAM_AW-1:0] ridx_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar b = 0; b < 2; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && be[b]) mem[widx][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/sermod_stop_ctrl.sv
module sermod_stop_ctrl
  import sermod_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int RAM_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              sub_clk_en,
  output logic              spi_halt_req,
  input  logic              spi_active,
  input  logic              spi_entry_end,
  input  logic [RAM_AW-1:0] spi_ram_idx,
  output logic [15:0]       spi_ram_data,
  output logic [2:0]        irq_level,
  output logic [7:0]        irq_vector
);
  localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_INT = ADDR_W'(1);

  region_e           region;
  logic              stop, halt, halt_ack;
  logic [DATA_W-1:0] cfg_word, int_word, ram_word, rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    if (bus_addr[ADDR_W-1])       region = SEL_RAM;
    else if (bus_addr == ADDR_CFG) region = SEL_CFG;
    else if (bus_addr == ADDR_INT) region = SEL_INT;
    else                           region = SEL_NONE;
  end

  sermod_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(bus_sel && bus_wr && region == SEL_CFG),
    .int_we(bus_sel && bus_wr && region == SEL_INT),
    .be(bus_be), .wdata(bus_wdata), .halt_ack_i(halt_ack),
    .stop_o(stop), .halt_o(halt), .lvl_o(irq_level), .vec_o(irq_vector),
    .cfg_word_o(cfg_word), .int_word_o(int_word)
  );

  sermod_halt u_halt (
    .clk(clk), .rst_n(rst_n), .halt_i(halt),
    .spi_active(spi_active), .spi_entry_end(spi_entry_end),
    .halt_ack_o(halt_ack)
  );

  sermod_qram #(.RAM_AW(RAM_AW)) u_qram (
    .clk(clk), .we(bus_sel && bus_wr && region == SEL_RAM), .be(bus_be),
    .widx(bus_addr[RAM_AW-1:0]), .wdata(bus_wdata),
    .ridx_a(bus_addr[RAM_AW-1:0]), .rdata_a(ram_word),
    .ridx_b(spi_ram_idx), .rdata_b(spi_ram_data)
  );

  always_comb begin
    unique case (region)
      SEL_CFG: rd_mux = cfg_word;
      SEL_INT: rd_mux = stop ? '0 : int_word;
      SEL_RAM: rd_mux = stop ? '0 : ram_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_sel && !bus_wr;
      rdata_q  <= (bus_sel && !bus_wr) ? rd_mux : '0;
    end
  end

  assign bus_rdata    = rdata_q;
  assign bus_rvalid   = rvalid_q;
  assign sub_clk_en   = !stop;
  assign spi_halt_req = halt;

  // R11: each read is answered on the following cycle
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);
  // R4: reads away from the configuration word are masked while stopped
  assert_stop_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && stop && bus_addr != ADDR_CFG) |=> (bus_rdata == 16'h0000));
  // R2: enable follows the stop write one cycle later
  assert_clk_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_CFG && bus_be[1])
      |=> (sub_clk_en == !$past(bus_wdata[STOP_BIT])));
endmodule

// File: tb/sim_sermod_stop_ctrl.sv
`timescale 1ns/100ps
module sim_sermod_stop_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, spi_ram_data;
  logic        bus_rvalid, sub_clk_en, spi_halt_req;
  logic        spi_active = 1'b1, spi_entry_end = 1'b0;
  logic [3:0]  spi_ram_idx = 4'd3;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sermod_stop_ctrl u0 (.*);

  // behavioural reference state
  bit          m_stop = 1, m_halt = 0, m_ack = 0;
  int          m_arb = 0, m_lvl = 0, m_vec = 8'h0F;
  logic [15:0] m_ram [16];
  bit          m_rv = 0;
  logic [15:0] m_rd = 0;
  string       m_tag = "R11";

  function automatic logic [15:0] m_cfg();
    return {m_stop, 7'b0, m_halt, m_ack, 2'b0, 4'(m_arb)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stop = 1; m_halt = 0; m_ack = 0; m_arb = 0; m_lvl = 0; m_vec = 8'h0F;
      m_rv = 0; m_rd = 0;
    end else begin
      bit old_halt;
      old_halt = m_halt;
      m_rv = bus_sel && !bus_wr;
      m_rd = 0;
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 0) begin m_rd = m_cfg(); m_tag = "R3 R8 R9 R10"; end
        else if (m_stop) begin m_rd = 0; m_tag = "R4"; end
        else if (bus_addr == 1) begin m_rd = {5'b0, 3'(m_lvl), 8'(m_vec)}; m_tag = "R6 R5 R7"; end
        else if (bus_addr[4]) begin m_rd = m_ram[bus_addr[3:0]]; m_tag = "R5"; end
        else begin m_rd = 0; m_tag = "R7"; end
      end
      if (bus_sel && bus_wr) begin
        if (bus_addr == 0) begin
          if (bus_be[1]) m_stop = bus_wdata[15];
          if (bus_be[0]) begin m_halt = bus_wdata[7]; m_arb = bus_wdata[3:0]; end
        end else if (bus_addr == 1) begin
          if (bus_be[1]) m_lvl = bus_wdata[10:8];
          if (bus_be[0]) m_vec = bus_wdata[7:0];
        end else if (bus_addr[4]) begin
          if (bus_be[1]) m_ram[bus_addr[3:0]][15:8] = bus_wdata[15:8];
          if (bus_be[0]) m_ram[bus_addr[3:0]][7:0]  = bus_wdata[7:0];
        end
      end
      m_ack = old_halt && (m_ack || spi_entry_end || !spi_active);
    end
  end

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("R2 clk enable", 16'(sub_clk_en), 16'(!m_stop));
    cmp("R8 halt request", 16'(spi_halt_req), 16'(m_halt));
    cmp("R11 rvalid", 16'(bus_rvalid), 16'(m_rv));
    if (m_rv) cmp({m_tag, " rdata"}, bus_rdata, m_rd);
    cmp("R6 level", 16'(irq_level), 16'(m_lvl));
    cmp("R6 vector", 16'(irq_vector), 16'(m_vec));
    if (m_ram[spi_ram_idx] !== 16'hxxxx && !$isunknown(m_ram[spi_ram_idx]))
      cmp("R12 spi ram port", spi_ram_data, m_ram[spi_ram_idx]);
  end

  task automatic wr(input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_ram[i] = 16'hxxxx;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    cmp("R1 clk enable", 16'(sub_clk_en), 16'h0);
    cmp("R1 halt request", 16'(spi_halt_req), 16'h0);
    cmp("R1 rvalid", 16'(bus_rvalid), 16'h0);
    cmp("R1 vector", 16'(irq_vector), 16'h000F);
    rst_n = 1;
    rd(5'd0);                       // R3 reset config 0x8000
    rd(5'd1);                       // R4 masked while stopped
    wr(5'd0, 2'b11, 16'h0005);      // R2 leave stop
    rd(5'd0); rd(5'd1);             // R1 vector 0x0F visible
    wr(5'd0, 2'b01, 16'h8000);      // R2 no byte 1 -> stop unchanged
    rd(5'd0);
    wr(5'd0, 2'b11, 16'hFFFF);      // R7 R2 stop+halt, busy SPI
    rd(5'd0);
    wr(5'd1, 2'b11, 16'hA5C3);      // R5 write while stopped
    wr(5'd19, 2'b11, 16'h1234);     // R5 RAM write while stopped
    rd(5'd1); rd(5'd19); rd(5'd2);  // R4
    @(negedge clk); spi_entry_end = 1;  // R8 boundary
    @(negedge clk); spi_entry_end = 0;
    rd(5'd0);
    wr(5'd0, 2'b11, 16'h004F);      // R9 R10 clear halt, try ack bit
    rd(5'd0); rd(5'd1); rd(5'd19);
    wr(5'd1, 2'b01, 16'h0711);      // R6 vector only
    rd(5'd1);
    wr(5'd1, 2'b10, 16'hFF00);      // R6 R7 level only
    rd(5'd1);
    spi_active = 0;
    wr(5'd0, 2'b01, 16'h0080);      // R8 idle SPI acks
    rd(5'd0);
    wr(5'd0, 2'b01, 16'h0000);      // R9
    rd(5'd0); rd(5'd2);             // R7 unmapped
    wr(5'd24, 2'b10, 16'hBEEF);     // R12 partial write
    spi_ram_idx = 4'd8;
    rd(5'd24);
    idle(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule